// File: doc/BRIEF.md
# Fast Ethernet Transceiver Mode Controller

This block is the mode-control slice of one port of a multi-port 10/100 Ethernet transceiver. It holds the 16-bit basic-mode control word, which is read and written through a parallel management port, and from it drives the port's operating and test modes. The modes are software reset, electrical isolation from the MII, internal loopback, collision test and duplex selection. The block also produces the enable bits that bypass the scrambler, the line encoder and the nibble encoder. Those datapaths lie outside the block and take the bits as plain control outputs.

The block sits between the MAC-facing MII and the transceiver's line-side datapath. It steers transmit and receive nibbles, receive-valid and collision to suit the active mode. It also drives the output enable of the MII pins. The block keeps a 5-bit management address. Three strap inputs supply the upper bits and the `PORT_IDX` parameter supplies the lower two. The address is captured when a qualified hardware reset pulse ends, and a management access counts only when it carries this address.

Top module: `phy_mode_ctrl`

## Requirements
- R1: A management write with bit 15 set starts a software reset. All other control bits clear on that write. `port_rst_o` and read-back bit 15 stay 1 for exactly `SRST_CYCLES` cycles (16 by default), then both return to 0 by themselves. Writes that arrive while the software reset is active are ignored.
- R2: A write with bit 15 at 0 starts no reset. `port_rst_o` stays 0, and the other written bits take effect.
- R3: Bit 10 = 1 selects isolation. `mii_oe_o` goes low. The MII outputs, `line_tx_en_o` and `line_txd_o` are held at 0, and the MII inputs have no effect. Management reads and writes keep working.
- R4: Bit 14 = 1 selects loopback. `mii_rx_dv_o`/`mii_rxd_o` follow `tx_en_i`/`txd_i`, `line_tx_en_o` is 0, and the line receive and collision inputs are ignored.
- R5: Bit 7 = 1 selects collision test. In half duplex, and when not isolated, `mii_col_o` equals `tx_en_i`, with or without loopback.
- R6: `full_dup_o` follows `aneg_fdx_i` when `aneg_en_i` = 1. Otherwise it is bit 8 OR `fdx_pin_i`. While `full_dup_o` = 1, `mii_col_o` is 0 in every mode. After reset the port is in half duplex.
- R7: Bits 2, 1 and 0 select the scrambler, line-encoder and nibble-encoder bypass and drive `byp_scr_o`, `byp_mlt_o` and `byp_enc_o`. Only bits 15, 14, 10, 8, 7, 2, 1 and 0 exist. All other bits read 0 and ignore writes, so writing 16'h7FFF reads back 16'h4587.
- R8: A management access takes effect only when `mgmt_addr_i` equals the latched port address. A write to another address changes nothing, and a read from another address returns 0.
- R9: `hw_rst_ni` is sampled on the clock. A low pulse counts as a reset only after `ceil(MIN_RST_NS/CLK_PERIOD_NS)` consecutive low samples (20 at the defaults). From that sample until release, `port_rst_o` is 1 and the control word is held at 0. A pulse one sample shorter changes nothing.
- R10: On the first high sample after a qualified hardware reset, the port address becomes {`strap_i`, `PORT_IDX`}. Otherwise it stays unchanged.
- R11: In normal mode (no isolate, no loopback), the transmit inputs pass to `line_tx_en_o`/`line_txd_o` and the line receive inputs pass to `mii_rx_dv_o`/`mii_rxd_o`. In half duplex, `line_col_i` passes to `mii_col_o`, and `mii_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| hw_rst_ni | input | 1 | Hardware reset pin, active low, length-qualified |
| strap_i | input | STRAP_W | Address strap pins |
| mgmt_req_i | input | 1 | Management access request |
| mgmt_we_i | input | 1 | 1 = write, 0 = read |
| mgmt_addr_i | input | STRAP_W+2 | Target port address |
| mgmt_wdata_i | input | 16 | Write data |
| mgmt_rdata_o | output | 16 | Read data of the control word, 0 when not addressed |
| aneg_en_i | input | 1 | Auto-negotiation enabled |
| aneg_fdx_i | input | 1 | Duplex resolved by auto-negotiation |
| fdx_pin_i | input | 1 | External full-duplex enable pin |
| tx_en_i | input | 1 | MII transmit enable |
| txd_i | input | DATA_W | MII transmit nibble |
| line_rx_dv_i | input | 1 | Receive valid from line datapath |
| line_rxd_i | input | DATA_W | Receive nibble from line datapath |
| line_col_i | input | 1 | Collision from line datapath |
| line_tx_en_o | output | 1 | Transmit enable to line datapath |
| line_txd_o | output | DATA_W | Transmit nibble to line datapath |
| mii_rx_dv_o | output | 1 | MII receive valid |
| mii_rxd_o | output | DATA_W | MII receive nibble |
| mii_col_o | output | 1 | MII collision |
| mii_oe_o | output | 1 | Output enable for the MII output pins |
| full_dup_o | output | 1 | Active duplex, 1 = full |
| byp_scr_o | output | 1 | Scrambler bypass |
| byp_mlt_o | output | 1 | Line-encoder bypass |
| byp_enc_o | output | 1 | Nibble-encoder bypass |
| port_rst_o | output | 1 | Internal port reset (hardware or software) |

## Verification
The assertions check the mode gating on every cycle:
- isolation silences the MII and line outputs;
- loopback keeps the line quiet and mirrors transmit into receive;
- collision test makes `mii_col_o` follow `tx_en_i`;
- full duplex keeps collision low;
- a software reset starts on a bit-15 write and lasts exactly the set number of cycles;
- a write with bit 15 at 0 never starts one;
- the port address changes only at a qualified reset release.

Other behaviour needs directed stimulus from the bench:
- the 19-versus-20-sample boundary of the hardware-reset qualifier;
- the read-back mask of the control word;
- rejection of accesses to a foreign address, and the move to a new address after re-strapping;
- writes ignored during a software reset;
- the exact duplex source chosen for each combination of auto-negotiation and pin.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;
  localparam int CTRL_W    = 16;
  localparam int B_RST     = 15;
  localparam int B_LOOP    = 14;
  localparam int B_ISO     = 10;
  localparam int B_FDX     = 8;
  localparam int B_COLT    = 7;
  localparam int B_BYP_SCR = 2;
  localparam int B_BYP_MLT = 1;
  localparam int B_BYP_ENC = 0;

  // storable bits, reset bit excluded (it is a status view of the sequencer)
  localparam logic [CTRL_W-1:0] STORE_MASK =
      (CTRL_W'(1) << B_LOOP) | (CTRL_W'(1) << B_ISO) | (CTRL_W'(1) << B_FDX) |
      (CTRL_W'(1) << B_COLT) | (CTRL_W'(1) << B_BYP_SCR) |
      (CTRL_W'(1) << B_BYP_MLT) | (CTRL_W'(1) << B_BYP_ENC);

  typedef struct packed {
    logic loop;
    logic iso;
    logic fdx;
    logic colt;
    logic byp_scr;
    logic byp_mlt;
    logic byp_enc;
  } mode_t;
endpackage

// File: rtl/phy_rst_qual.sv
module phy_rst_qual #(
  parameter int   MIN_CYC  = 20,
  parameter int   STRAP_W  = 3,
  parameter logic [1:0] PORT_IDX = 2'd0,
  localparam int  ADDR_W   = STRAP_W + 2,
  localparam int  CNT_W    = $clog2(MIN_CYC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hw_rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               hw_rst_o,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             qual_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      qual_q <= 1'b0;
      addr_o <= {{STRAP_W{1'b0}}, PORT_IDX};
    end else if (!hw_rst_ni) begin
      if (!qual_q) begin
        if (cnt_q == CNT_W'(MIN_CYC - 1)) qual_q <= 1'b1;
        else                              cnt_q  <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
      if (qual_q) begin
        qual_q <= 1'b0;
        addr_o <= {strap_i, PORT_IDX};
      end
    end
  end

  assign hw_rst_o = qual_q;
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_mode_pkg::*;
#(
  parameter int  SRST_CYCLES = 16,
  parameter int  ADDR_W      = 5,
  localparam int SC_W        = $clog2(SRST_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_rst_i,
  input  logic [ADDR_W-1:0] port_addr_i,
  input  logic              mgmt_req_i,
  input  logic              mgmt_we_i,
  input  logic [ADDR_W-1:0] mgmt_addr_i,
  input  logic [CTRL_W-1:0] mgmt_wdata_i,
  output logic [CTRL_W-1:0] mgmt_rdata_o,
  output mode_t             mode_o,
  output logic              sw_rst_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [SC_W-1:0]   sc_q;
  logic              busy_q;
  logic              hit, wr;

  assign hit = mgmt_req_i && (mgmt_addr_i == port_addr_i);
  assign wr  = hit && mgmt_we_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      busy_q <= 1'b0;
      sc_q   <= '0;
    end else if (hw_rst_i) begin
      ctrl_q <= '0;
      busy_q <= 1'b0;
      sc_q   <= '0;
    end else if (busy_q) begin
      ctrl_q <= '0;
      if (sc_q == SC_W'(SRST_CYCLES - 1)) busy_q <= 1'b0;
      else                                sc_q   <= sc_q + 1'b1;
    end else if (wr) begin
      if (mgmt_wdata_i[B_RST]) begin
        busy_q <= 1'b1;
        sc_q   <= '0;
        ctrl_q <= '0;
      end else begin
        ctrl_q <= mgmt_wdata_i & STORE_MASK;
      end
    end
  end

  always_comb begin
    mgmt_rdata_o = '0;
    if (hit && !mgmt_we_i) begin
      mgmt_rdata_o        = ctrl_q;
      mgmt_rdata_o[B_RST] = busy_q;
    end
  end

  assign mode_o.loop    = ctrl_q[B_LOOP];
  assign mode_o.iso     = ctrl_q[B_ISO];
  assign mode_o.fdx     = ctrl_q[B_FDX];
  assign mode_o.colt    = ctrl_q[B_COLT];
  assign mode_o.byp_scr = ctrl_q[B_BYP_SCR];
  assign mode_o.byp_mlt = ctrl_q[B_BYP_MLT];
  assign mode_o.byp_enc = ctrl_q[B_BYP_ENC];
  assign sw_rst_o       = busy_q;
endmodule

// File: rtl/phy_mii_gate.sv
module phy_mii_gate #(
  parameter int DATA_W = 4
) (
  input  logic              loop_i,
  input  logic              iso_i,
  input  logic              colt_i,
  input  logic              full_dup_i,
  input  logic              tx_en_i,
  input  logic [DATA_W-1:0] txd_i,
  input  logic              line_rx_dv_i,
  input  logic [DATA_W-1:0] line_rxd_i,
  input  logic              line_col_i,
  output logic              line_tx_en_o,
  output logic [DATA_W-1:0] line_txd_o,
  output logic              mii_rx_dv_o,
  output logic [DATA_W-1:0] mii_rxd_o,
  output logic              mii_col_o,
  output logic              mii_oe_o
);
  always_comb begin
    line_tx_en_o = 1'b0;
    line_txd_o   = '0;
    mii_rx_dv_o  = 1'b0;
    mii_rxd_o    = '0;
    mii_col_o    = 1'b0;
    mii_oe_o     = 1'b0;
    if (!iso_i) begin
      mii_oe_o = 1'b1;
      if (loop_i) begin
        mii_rx_dv_o = tx_en_i;
        mii_rxd_o   = txd_i;
      end else begin
        line_tx_en_o = tx_en_i;
        line_txd_o   = txd_i;
        mii_rx_dv_o  = line_rx_dv_i;
        mii_rxd_o    = line_rxd_i;
      end
      // duplex outranks collision test, which outranks loopback
      if (full_dup_i)  mii_col_o = 1'b0;
      else if (colt_i) mii_col_o = tx_en_i;
      else if (loop_i) mii_col_o = 1'b0;
      else             mii_col_o = line_col_i;
    end
  end
endmodule

// File: rtl/phy_mode_ctrl.sv
module phy_mode_ctrl
  import phy_mode_pkg::*;
#(
  parameter int   CLK_PERIOD_NS = 20,
  parameter int   MIN_RST_NS    = 400,
  parameter int   SRST_CYCLES   = 16,
  parameter int   STRAP_W       = 3,
  parameter int   DATA_W        = 4,
  parameter logic [1:0] PORT_IDX = 2'd0,
  localparam int  ADDR_W        = STRAP_W + 2,
  localparam int  MIN_CYC       = (MIN_RST_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hw_rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               mgmt_req_i,
  input  logic               mgmt_we_i,
  input  logic [ADDR_W-1:0]  mgmt_addr_i,
  input  logic [15:0]        mgmt_wdata_i,
  output logic [15:0]        mgmt_rdata_o,
  input  logic               aneg_en_i,
  input  logic               aneg_fdx_i,
  input  logic               fdx_pin_i,
  input  logic               tx_en_i,
  input  logic [DATA_W-1:0]  txd_i,
  input  logic               line_rx_dv_i,
  input  logic [DATA_W-1:0]  line_rxd_i,
  input  logic               line_col_i,
  output logic               line_tx_en_o,
  output logic [DATA_W-1:0]  line_txd_o,
  output logic               mii_rx_dv_o,
  output logic [DATA_W-1:0]  mii_rxd_o,
  output logic               mii_col_o,
  output logic               mii_oe_o,
  output logic               full_dup_o,
  output logic               byp_scr_o,
  output logic               byp_mlt_o,
  output logic               byp_enc_o,
  output logic               port_rst_o
);
  logic              hw_rst;
  logic              sw_rst;
  logic [ADDR_W-1:0] port_addr;
  mode_t             mode;
  logic              full_dup;

  phy_rst_qual #(
    .MIN_CYC (MIN_CYC),
    .STRAP_W (STRAP_W),
    .PORT_IDX(PORT_IDX)
  ) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_rst_ni(hw_rst_ni),
    .strap_i  (strap_i),
    .hw_rst_o (hw_rst),
    .addr_o   (port_addr)
  );

  phy_ctrl_reg #(
    .SRST_CYCLES(SRST_CYCLES),
    .ADDR_W     (ADDR_W)
  ) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hw_rst_i    (hw_rst),
    .port_addr_i (port_addr),
    .mgmt_req_i  (mgmt_req_i),
    .mgmt_we_i   (mgmt_we_i),
    .mgmt_addr_i (mgmt_addr_i),
    .mgmt_wdata_i(mgmt_wdata_i),
    .mgmt_rdata_o(mgmt_rdata_o),
    .mode_o      (mode),
    .sw_rst_o    (sw_rst)
  );

  assign full_dup = aneg_en_i ? aneg_fdx_i : (mode.fdx | fdx_pin_i);

  phy_mii_gate #(.DATA_W(DATA_W)) u_gate (
    .loop_i      (mode.loop),
    .iso_i       (mode.iso),
    .colt_i      (mode.colt),
    .full_dup_i  (full_dup),
    .tx_en_i     (tx_en_i),
    .txd_i       (txd_i),
    .line_rx_dv_i(line_rx_dv_i),
    .line_rxd_i  (line_rxd_i),
    .line_col_i  (line_col_i),
    .line_tx_en_o(line_tx_en_o),
    .line_txd_o  (line_txd_o),
    .mii_rx_dv_o (mii_rx_dv_o),
    .mii_rxd_o   (mii_rxd_o),
    .mii_col_o   (mii_col_o),
    .mii_oe_o    (mii_oe_o)
  );

  assign full_dup_o = full_dup;
  assign byp_scr_o  = mode.byp_scr;
  assign byp_mlt_o  = mode.byp_mlt;
  assign byp_enc_o  = mode.byp_enc;
  assign port_rst_o = hw_rst | sw_rst;
endmodule

// File: rtl/phy_mode_ctrl_chk.sv
module phy_mode_ctrl_chk #(
  parameter int  SRST_CYCLES = 16,
  parameter int  ADDR_W      = 5,
  localparam int SC_W        = $clog2(SRST_CYCLES + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hw_rst_ni,
  input logic              hw_rst,
  input logic              sw_rst,
  input logic [ADDR_W-1:0] port_addr,
  input logic              loop,
  input logic              iso,
  input logic              colt,
  input logic              full_dup,
  input logic              mgmt_req_i,
  input logic              mgmt_we_i,
  input logic [ADDR_W-1:0] mgmt_addr_i,
  input logic              wdata_rst,
  input logic              tx_en_i,
  input logic              line_tx_en_o,
  input logic              mii_rx_dv_o,
  input logic              mii_col_o,
  input logic              mii_oe_o
);
  logic [SC_W-1:0] run_q;
  logic            wr_hit;

  assign wr_hit = mgmt_req_i && mgmt_we_i && (mgmt_addr_i == port_addr) &&
                  !sw_rst && !hw_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (sw_rst) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  a_r3_isolate_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iso |-> (!mii_oe_o && !line_tx_en_o && !mii_col_o && !mii_rx_dv_o));

  a_r4_loop_no_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop && !iso) |-> (!line_tx_en_o && (mii_rx_dv_o == tx_en_i)));

  a_r5_coltest_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (colt && !iso && !full_dup) |-> (mii_col_o == tx_en_i));

  a_r6_fdx_no_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_dup |-> !mii_col_o);

  a_r1_srst_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && wdata_rst) |=> sw_rst);

  a_r1_srst_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sw_rst) && !$past(hw_rst)) |-> (run_q == SC_W'(SRST_CYCLES)));

  a_r2_zero_no_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && !wdata_rst) |=> !sw_rst);

  a_r10_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hw_rst && hw_rst_ni) |=> $stable(port_addr));
endmodule

bind phy_mode_ctrl phy_mode_ctrl_chk #(
  .SRST_CYCLES(SRST_CYCLES),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hw_rst_ni   (hw_rst_ni),
  .hw_rst      (hw_rst),
  .sw_rst      (sw_rst),
  .port_addr   (port_addr),
  .loop        (mode.loop),
  .iso         (mode.iso),
  .colt        (mode.colt),
  .full_dup    (full_dup),
  .mgmt_req_i  (mgmt_req_i),
  .mgmt_we_i   (mgmt_we_i),
  .mgmt_addr_i (mgmt_addr_i),
  .wdata_rst   (mgmt_wdata_i[15]),
  .tx_en_i     (tx_en_i),
  .line_tx_en_o(line_tx_en_o),
  .mii_rx_dv_o (mii_rx_dv_o),
  .mii_col_o   (mii_col_o),
  .mii_oe_o    (mii_oe_o)
);

// File: tb/phy_mode_ctrl_test.sv
module phy_mode_ctrl_test;
  localparam logic [1:0] IDX = 2'b10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hw_rst_ni = 1'b0;
  logic [2:0] strap_i = 3'b101;
  logic       mgmt_req_i = 1'b0, mgmt_we_i = 1'b0;
  logic [4:0] mgmt_addr_i = '0;
  logic [15:0] mgmt_wdata_i = '0, mgmt_rdata_o;
  logic aneg_en_i = 1'b0, aneg_fdx_i = 1'b0, fdx_pin_i = 1'b0;
  logic tx_en_i = 1'b0, line_rx_dv_i = 1'b0, line_col_i = 1'b0;
  logic [3:0] txd_i = '0, line_rxd_i = '0;
  logic line_tx_en_o, mii_rx_dv_o, mii_col_o, mii_oe_o, full_dup_o;
  logic byp_scr_o, byp_mlt_o, byp_enc_o, port_rst_o;
  logic [3:0] line_txd_o, mii_rxd_o;

  int checks = 0;
  int errors = 0;
  logic [4:0] my_addr = {3'b101, IDX};

  always #10 clk_i = ~clk_i;

  phy_mode_ctrl #(.PORT_IDX(IDX)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hw_rst_ni(hw_rst_ni), .strap_i(strap_i),
    .mgmt_req_i(mgmt_req_i), .mgmt_we_i(mgmt_we_i), .mgmt_addr_i(mgmt_addr_i),
    .mgmt_wdata_i(mgmt_wdata_i), .mgmt_rdata_o(mgmt_rdata_o),
    .aneg_en_i(aneg_en_i), .aneg_fdx_i(aneg_fdx_i), .fdx_pin_i(fdx_pin_i),
    .tx_en_i(tx_en_i), .txd_i(txd_i), .line_rx_dv_i(line_rx_dv_i),
    .line_rxd_i(line_rxd_i), .line_col_i(line_col_i),
    .line_tx_en_o(line_tx_en_o), .line_txd_o(line_txd_o),
    .mii_rx_dv_o(mii_rx_dv_o), .mii_rxd_o(mii_rxd_o), .mii_col_o(mii_col_o),
    .mii_oe_o(mii_oe_o), .full_dup_o(full_dup_o), .byp_scr_o(byp_scr_o),
    .byp_mlt_o(byp_mlt_o), .byp_enc_o(byp_enc_o), .port_rst_o(port_rst_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk_i);
    mgmt_req_i = 1'b1; mgmt_we_i = 1'b1; mgmt_addr_i = a; mgmt_wdata_i = d;
    @(negedge clk_i);
    mgmt_req_i = 1'b0; mgmt_we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    mgmt_req_i = 1'b1; mgmt_we_i = 1'b0; mgmt_addr_i = a;
    #2;
    d = mgmt_rdata_o;
    mgmt_req_i = 1'b0;
    #1;
  endtask

  task automatic hw_pulse(input int n);
    @(negedge clk_i);
    hw_rst_ni = 1'b0;
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset_state;
    logic [15:0] d;
    rd(my_addr, d);
    check("R9", "control word after reset", d, 16'h0);
    check("R6", "half duplex after reset", full_dup_o, 1'b0);
    check("R11", "mii output enable after reset", mii_oe_o, 1'b1);
    check("R1", "no port reset after reset", port_rst_o, 1'b0);
  endtask

  task automatic t_normal;
    wr(my_addr, 16'h0000);
    tx_en_i = 1'b1; txd_i = 4'h5; line_rx_dv_i = 1'b1; line_rxd_i = 4'hA;
    line_col_i = 1'b1;
    #2;
    check("R11", "line tx nibble", {line_tx_en_o, line_txd_o}, 5'h15);
    check("R11", "mii rx nibble", {mii_rx_dv_o, mii_rxd_o}, 5'h1A);
    check("R11", "collision pass", mii_col_o, 1'b1);
    tx_en_i = 1'b0; line_rx_dv_i = 1'b0; line_col_i = 1'b0;
  endtask

  task automatic t_unimpl;
    logic [15:0] d;
    wr(my_addr, 16'h7FFF);
    rd(my_addr, d);
    check("R7", "readback mask", d, 16'h4587);
    check("R7", "bypass outputs all set", {byp_scr_o, byp_mlt_o, byp_enc_o}, 3'b111);
    wr(my_addr, 16'h0005);
    rd(my_addr, d);
    check("R7", "bypass readback", d, 16'h0005);
    check("R7", "bypass outputs 101", {byp_scr_o, byp_mlt_o, byp_enc_o}, 3'b101);
  endtask

  task automatic t_srst;
    logic [15:0] d;
    wr(my_addr, 16'h4000);
    check("R2", "zero bit15 starts no reset", port_rst_o, 1'b0);
    rd(my_addr, d);
    check("R2", "other bits applied", d, 16'h4000);
    wr(my_addr, 16'h8400);   // write edge = cycle 0
    rd(my_addr, d);
    check("R1", "bit15 reads 1, rest cleared", d, 16'h8000);
    check("R1", "port reset active", port_rst_o, 1'b1);
    wr(my_addr, 16'h0100);   // cycle 1, inside the window
    repeat (13) @(posedge clk_i);
    @(negedge clk_i);        // after cycle 15
    rd(my_addr, d);
    check("R1", "still in reset at cycle 15", d, 16'h8000);
    @(negedge clk_i);        // after cycle 16
    rd(my_addr, d);
    check("R1", "self-cleared, write ignored", d, 16'h0000);
    check("R1", "port reset released", port_rst_o, 1'b0);
  endtask

  task automatic t_isolate;
    logic [15:0] d;
    wr(my_addr, 16'h0400);
    tx_en_i = 1'b1; txd_i = 4'h7; line_rx_dv_i = 1'b1; line_rxd_i = 4'h3;
    line_col_i = 1'b1;
    #2;
    check("R3", "oe low", mii_oe_o, 1'b0);
    check("R3", "line tx quiet", {line_tx_en_o, line_txd_o}, 5'h0);
    check("R3", "mii outputs quiet", {mii_rx_dv_o, mii_rxd_o, mii_col_o}, 6'h0);
    rd(my_addr, d);
    check("R3", "management works", d, 16'h0400);
    wr(my_addr, 16'h0000);
    #2;
    check("R3", "oe back", mii_oe_o, 1'b1);
    tx_en_i = 1'b0; line_rx_dv_i = 1'b0; line_col_i = 1'b0;
  endtask

  task automatic t_loop;
    wr(my_addr, 16'h4000);
    tx_en_i = 1'b1; txd_i = 4'h9; line_rx_dv_i = 1'b1; line_rxd_i = 4'h3;
    line_col_i = 1'b1;
    #2;
    check("R4", "rx mirrors tx", {mii_rx_dv_o, mii_rxd_o}, 5'h19);
    check("R4", "line tx off", line_tx_en_o, 1'b0);
    check("R4", "line collision ignored", mii_col_o, 1'b0);
    wr(my_addr, 16'h0000);
    #2;
    check("R4", "normal restored", {mii_rx_dv_o, mii_rxd_o}, 5'h13);
    tx_en_i = 1'b0; line_rx_dv_i = 1'b0; line_col_i = 1'b0;
  endtask

  task automatic t_coltest;
    wr(my_addr, 16'h0080);
    tx_en_i = 1'b1; #2;
    check("R5", "col follows tx_en high", mii_col_o, 1'b1);
    tx_en_i = 1'b0; #2;
    check("R5", "col follows tx_en low", mii_col_o, 1'b0);
    wr(my_addr, 16'h4080);
    tx_en_i = 1'b1; #2;
    check("R5", "col test inside loopback", mii_col_o, 1'b1);
    tx_en_i = 1'b0;
    wr(my_addr, 16'h0000);
  endtask

  task automatic t_duplex;
    wr(my_addr, 16'h0100);
    line_col_i = 1'b1; #2;
    check("R6", "bit8 full duplex", full_dup_o, 1'b1);
    check("R6", "col masked in full duplex", mii_col_o, 1'b0);
    wr(my_addr, 16'h0180);
    tx_en_i = 1'b1; #2;
    check("R6", "col test masked in full duplex", mii_col_o, 1'b0);
    tx_en_i = 1'b0;
    wr(my_addr, 16'h0000);
    fdx_pin_i = 1'b1; #2;
    check("R6", "pin full duplex", full_dup_o, 1'b1);
    aneg_en_i = 1'b1; aneg_fdx_i = 1'b0; #2;
    check("R6", "aneg overrides pin", full_dup_o, 1'b0);
    aneg_fdx_i = 1'b1; #2;
    check("R6", "aneg full", full_dup_o, 1'b1);
    aneg_en_i = 1'b0; aneg_fdx_i = 1'b0; fdx_pin_i = 1'b0; #2;
    check("R6", "half duplex again, line col passes", mii_col_o, 1'b1);
    line_col_i = 1'b0;
  endtask

  task automatic t_addr;
    logic [15:0] d;
    logic [4:0] other = my_addr ^ 5'b00001;
    wr(other, 16'h4000);
    rd(my_addr, d);
    check("R8", "foreign write ignored", d, 16'h0000);
    wr(my_addr, 16'h4000);
    rd(other, d);
    check("R8", "foreign read returns 0", d, 16'h0000);
  endtask

  task automatic t_hwrst;
    logic [15:0] d;
    strap_i = 3'b011;
    hw_pulse(19);
    check("R9", "19-sample pulse not qualified", port_rst_o, 1'b0);
    hw_rst_ni = 1'b1;
    @(negedge clk_i);
    rd(my_addr, d);
    check("R9", "short pulse keeps word", d, 16'h4000);
    check("R10", "short pulse keeps address", d[14], 1'b1);
    hw_pulse(20);
    check("R9", "20-sample pulse qualified", port_rst_o, 1'b1);
    hw_rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R9", "reset released", port_rst_o, 1'b0);
    my_addr = {3'b011, IDX};
    rd(my_addr, d);
    check("R9", "word cleared by hw reset", d, 16'h0000);
    wr(my_addr, 16'h0400);
    rd(my_addr, d);
    check("R10", "new address accepts access", d, 16'h0400);
    rd({3'b101, IDX}, d);
    check("R10", "old address dead", d, 16'h0000);
    wr(my_addr, 16'h0000);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (25) @(negedge clk_i);
    hw_rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset_state();
    t_normal();
    t_unimpl();
    t_srst();
    t_isolate();
    t_loop();
    t_coltest();
    t_duplex();
    t_addr();
    t_hwrst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule